// File: doc/BRIEF.md
# Region Access Permission Checker

This block decides whether a single bus access may proceed, given a table of address-range descriptors. Each access carries an address, the number of the bus master that issued it, an access kind (read, write or execute), a supervisor/user mode bit and a process identifier. Each descriptor gives an inclusive address window, a valid bit, a 32-bit permission word with one field per master, and a process identifier with an ignore mask.

Two classes of master are checked. Low-numbered privileged masters have a user rights mask, a supervisor rights code and a process-identifier qualifier. Higher-numbered plain masters have only read and write enables. The access is sampled on a one-cycle request strobe, and the verdict appears on the next clock edge. The verdict is a deny bit plus three mutually exclusive hit-count flags that a separate error-capture block can use to classify the fault. Descriptor programming happens elsewhere: the descriptors arrive here as static flat vectors.

Top module: `region_guard`

## Requirements
- R1: A region covers the addresses from its start with the low 5 bits forced to 0 through its end with the low 5 bits forced to 1, both limits inclusive.
- R2: A region whose valid bit is 0 never counts as a hit, whatever its window and permissions.
- R3: Privileged master n (n < 4) uses permission bits [6n+5:6n]. Bits [6n+2:6n] are a user mask with bit 2 = read, bit 1 = write and bit 0 = execute. The access kind code is 0 = read, 1 = write, 2 = execute, and 3 is also checked as execute.
- R4: For a privileged master in supervisor mode, the code in bits [6n+4:6n+3] grants 0 = read/write/execute, 1 = read/execute, 2 = read/write, and 3 = the user mask.
- R5: Plain master n (4..7) uses permission bits [24+2(n-4)+1 : 24+2(n-4)], with bit 0 of the pair = read enable and bit 1 = write enable. An execute access from such a master is checked as a read. The mode bit does not affect it.
- R6: When bit 6n+5 is set for privileged master n, the region hits only if the access identifier equals the region identifier in every bit where the region mask is 0. Plain masters are never qualified by identifier.
- R7: When several regions hit, the access is granted if at least one hitting region allows it, and denied only if all of them refuse it.
- R8: With checking enabled, every verdict raises exactly one of the no-hit, single-hit and multi-hit flags, and a no-hit verdict is always a deny.
- R9: With the global enable at 0, the verdict grants the access and all three hit flags are 0.
- R10: The verdict-valid output is high exactly in the cycle after a request cycle. Deny and the hit flags are 0 whenever verdict-valid is 0.
- R11: During and immediately after reset, verdict-valid, deny and all hit flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| globalEn | input | 1 | Checking enable; at 0 every access is granted |
| reqValid | input | 1 | One-cycle access request strobe |
| reqAddr | input | 32 | Access address |
| reqMaster | input | 3 | Bus master number |
| reqKind | input | 2 | 0 read, 1 write, 2 or 3 execute |
| reqSuper | input | 1 | 1 = supervisor mode, 0 = user mode |
| reqPid | input | 8 | Access process identifier |
| regStart | input | 256 | Region start addresses, region i at bits [32i+31:32i] |
| regEnd | input | 256 | Region end addresses, same packing |
| regValid | input | 8 | Region valid bits, bit i for region i |
| regPerm | input | 256 | Region permission words, same packing as the addresses |
| regPid | input | 64 | Region process identifiers, 8 bits per region |
| regPidMask | input | 64 | Region identifier ignore masks, 8 bits per region |
| verdictValid | output | 1 | Verdict present this cycle |
| deny | output | 1 | Access refused |
| noHit | output | 1 | No region matched |
| oneHit | output | 1 | Exactly one region matched |
| multiHit | output | 1 | Two or more regions matched |

## Verification
The in-RTL properties watch the cycle-level contract on every clock. They check that verdict-valid follows a request by exactly one cycle, that exactly one hit flag rises on an enabled verdict, that a no-hit verdict denies, and that a bypassed or idle cycle leaves deny and the flags low. The properties cannot tell whether a verdict is correct for a given descriptor set. That needs the bench's scenarios: window edges after rounding, each supervisor code, the plain-master bit pairs and execute-as-read, identifier masking, overlapping regions that mix grant and refusal, and invalid regions.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

  // Access kind codes seen on reqKind
  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_EXEC  = 2'd2,
    KIND_EXEC2 = 2'd3
  } accKind_e;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic load;    // capture an enabled verdict
    logic bypass;  // checking disabled: grant, no flags
  } guardStrobe_t;

  localparam int unsigned FIELD_W   = 6;  // privileged master field width
  localparam int unsigned PLAIN_W   = 2;  // plain master field width
  localparam int unsigned GRAN_BITS = 5;  // 32-byte granularity

endpackage

// File: rtl/region_lane.sv
module region_lane
  import region_guard_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned PID_W        = 8,
  parameter int unsigned NUM_MASTERS  = 8,
  parameter int unsigned PRIV_MASTERS = 4,
  parameter int unsigned PERM_W       = 32,
  localparam int unsigned MST_W       = $clog2(NUM_MASTERS)
) (
  input  logic [ADDR_W-1:0] regStart,
  input  logic [ADDR_W-1:0] regEnd,
  input  logic              regValid,
  input  logic [PERM_W-1:0] regPerm,
  input  logic [PID_W-1:0]  regPid,
  input  logic [PID_W-1:0]  regPidMask,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [MST_W-1:0]  reqMaster,
  input  logic [1:0]        reqKind,
  input  logic              reqSuper,
  input  logic [PID_W-1:0]  reqPid,
  output logic              hit,
  output logic              allow
);

  localparam logic [ADDR_W-1:0] GRAN_MASK = ADDR_W'((1 << GRAN_BITS) - 1);

  logic [ADDR_W-1:0] loAddr, hiAddr;
  logic              inRange, pidOk, pidEn;
  logic [2:0]        rwx, need;
  logic [FIELD_W-1:0] field;
  logic [PLAIN_W-1:0] pair;

  assign loAddr  = regStart & ~GRAN_MASK;
  assign hiAddr  = regEnd | GRAN_MASK;
  assign inRange = (reqAddr >= loAddr) && (reqAddr <= hiAddr);

  // Rights of the requesting master as a {read, write, execute} mask
  always_comb begin
    rwx   = 3'b000;
    pidEn = 1'b0;
    field = '0;
    pair  = '0;
    for (int m = 0; m < PRIV_MASTERS; m++) begin
      if (reqMaster == MST_W'(m)) begin
        field = regPerm[FIELD_W*m +: FIELD_W];
        pidEn = field[5];
        if (reqSuper) begin
          unique case (field[4:3])
            2'd0:    rwx = 3'b111;
            2'd1:    rwx = 3'b101;
            2'd2:    rwx = 3'b110;
            default: rwx = field[2:0];
          endcase
        end else begin
          rwx = field[2:0];
        end
      end
    end
    for (int m = PRIV_MASTERS; m < NUM_MASTERS; m++) begin
      if (reqMaster == MST_W'(m)) begin
        pair = regPerm[FIELD_W*PRIV_MASTERS + PLAIN_W*(m-PRIV_MASTERS) +: PLAIN_W];
        rwx  = {pair[0], pair[1], pair[0]};  // execute checked as read
      end
    end
  end

  always_comb begin
    unique case (accKind_e'(reqKind))
      KIND_READ:  need = 3'b100;
      KIND_WRITE: need = 3'b010;
      default:    need = 3'b001;
    endcase
  end

  assign pidOk = !pidEn || (((reqPid ^ regPid) & ~regPidMask) == '0);
  assign hit   = regValid && inRange && pidOk;
  assign allow = hit && ((rwx & need) != 3'b000);

endmodule

// File: rtl/region_datapath.sv
module region_datapath
  import region_guard_pkg::*;
#(
  parameter int unsigned NUM_REGIONS  = 8,
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned PID_W        = 8,
  parameter int unsigned NUM_MASTERS  = 8,
  parameter int unsigned PRIV_MASTERS = 4,
  parameter int unsigned PERM_W       = 32,
  localparam int unsigned MST_W       = $clog2(NUM_MASTERS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  guardStrobe_t                  strobe,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [MST_W-1:0]              reqMaster,
  input  logic [1:0]                    reqKind,
  input  logic                          reqSuper,
  input  logic [PID_W-1:0]              reqPid,
  input  logic [NUM_REGIONS*ADDR_W-1:0] regStart,
  input  logic [NUM_REGIONS*ADDR_W-1:0] regEnd,
  input  logic [NUM_REGIONS-1:0]        regValid,
  input  logic [NUM_REGIONS*PERM_W-1:0] regPerm,
  input  logic [NUM_REGIONS*PID_W-1:0]  regPid,
  input  logic [NUM_REGIONS*PID_W-1:0]  regPidMask,
  output logic                          deny,
  output logic                          noHit,
  output logic                          oneHit,
  output logic                          multiHit
);

  logic [NUM_REGIONS-1:0] hitVec, allowVec;
  logic                   anyHit, severalHits;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_lane
    region_lane #(
      .ADDR_W(ADDR_W), .PID_W(PID_W), .NUM_MASTERS(NUM_MASTERS),
      .PRIV_MASTERS(PRIV_MASTERS), .PERM_W(PERM_W)
    ) lane_i (
      .regStart  (regStart[r*ADDR_W +: ADDR_W]),
      .regEnd    (regEnd[r*ADDR_W +: ADDR_W]),
      .regValid  (regValid[r]),
      .regPerm   (regPerm[r*PERM_W +: PERM_W]),
      .regPid    (regPid[r*PID_W +: PID_W]),
      .regPidMask(regPidMask[r*PID_W +: PID_W]),
      .reqAddr   (reqAddr),
      .reqMaster (reqMaster),
      .reqKind   (reqKind),
      .reqSuper  (reqSuper),
      .reqPid    (reqPid),
      .hit       (hitVec[r]),
      .allow     (allowVec[r])
    );
  end

  assign anyHit      = |hitVec;
  assign severalHits = |(hitVec & (hitVec - NUM_REGIONS'(1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      deny     <= 1'b0;
      noHit    <= 1'b0;
      oneHit   <= 1'b0;
      multiHit <= 1'b0;
    end else if (strobe.load) begin
      deny     <= !(|allowVec);
      noHit    <= !anyHit;
      oneHit   <= anyHit && !severalHits;
      multiHit <= severalHits;
    end else begin
      deny     <= 1'b0;
      noHit    <= 1'b0;
      oneHit   <= 1'b0;
      multiHit <= 1'b0;
    end
  end

  // R8: an enabled verdict carries exactly one hit class
  assert_one_class_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> $countones({noHit, oneHit, multiHit}) == 1);

  // R8: nothing matched means refused
  assert_nohit_denies_R8: assert property (@(posedge clk) disable iff (!rstN)
    noHit |-> deny);

  // R9: disabled checking grants with no flags
  assert_bypass_grants_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.bypass |=> !deny && !noHit && !oneHit && !multiHit);

  // R10: without a request the verdict outputs stay low
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load || strobe.bypass) |=> !deny && !noHit && !oneHit && !multiHit);

endmodule

// File: rtl/region_ctrl.sv
module region_ctrl
  import region_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         globalEn,
  input  logic         reqValid,
  output guardStrobe_t strobe,
  output logic         verdictValid
);

  assign strobe.load   = reqValid && globalEn;
  assign strobe.bypass = reqValid && !globalEn;

  always_ff @(posedge clk) begin
    if (!rstN) verdictValid <= 1'b0;
    else       verdictValid <= reqValid;
  end

  // R10: verdict follows a request by one cycle, never otherwise
  assert_verdict_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> verdictValid);
  assert_no_spurious_verdict_R10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !verdictValid);

endmodule

// File: rtl/region_guard.sv
module region_guard
  import region_guard_pkg::*;
#(
  parameter int unsigned NUM_REGIONS  = 8,
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned PID_W        = 8,
  parameter int unsigned NUM_MASTERS  = 8,
  parameter int unsigned PRIV_MASTERS = 4,
  parameter int unsigned PERM_W       = 32,
  localparam int unsigned MST_W       = $clog2(NUM_MASTERS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          globalEn,
  input  logic                          reqValid,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [MST_W-1:0]              reqMaster,
  input  logic [1:0]                    reqKind,
  input  logic                          reqSuper,
  input  logic [PID_W-1:0]              reqPid,
  input  logic [NUM_REGIONS*ADDR_W-1:0] regStart,
  input  logic [NUM_REGIONS*ADDR_W-1:0] regEnd,
  input  logic [NUM_REGIONS-1:0]        regValid,
  input  logic [NUM_REGIONS*PERM_W-1:0] regPerm,
  input  logic [NUM_REGIONS*PID_W-1:0]  regPid,
  input  logic [NUM_REGIONS*PID_W-1:0]  regPidMask,
  output logic                          verdictValid,
  output logic                          deny,
  output logic                          noHit,
  output logic                          oneHit,
  output logic                          multiHit
);

  guardStrobe_t strobe;

  region_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .reqValid(reqValid),
    .strobe(strobe), .verdictValid(verdictValid)
  );

  region_datapath #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .PID_W(PID_W),
    .NUM_MASTERS(NUM_MASTERS), .PRIV_MASTERS(PRIV_MASTERS), .PERM_W(PERM_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqAddr(reqAddr), .reqMaster(reqMaster), .reqKind(reqKind),
    .reqSuper(reqSuper), .reqPid(reqPid),
    .regStart(regStart), .regEnd(regEnd), .regValid(regValid),
    .regPerm(regPerm), .regPid(regPid), .regPidMask(regPidMask),
    .deny(deny), .noHit(noHit), .oneHit(oneHit), .multiHit(multiHit)
  );

endmodule

// File: tb/region_guard_tb_top.sv
`timescale 1ns/1ps
module region_guard_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        globalEn = 1'b1;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [2:0]  reqMaster = '0;
  logic [1:0]  reqKind = '0;
  logic        reqSuper = 1'b0;
  logic [7:0]  reqPid = '0;
  logic [255:0] regStart, regEnd, regPerm;
  logic [7:0]   regValid;
  logic [63:0]  regPid, regPidMask;
  logic verdictValid, deny, noHit, oneHit, multiHit;

  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  region_guard dut_i (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqMaster(reqMaster), .reqKind(reqKind),
    .reqSuper(reqSuper), .reqPid(reqPid),
    .regStart(regStart), .regEnd(regEnd), .regValid(regValid),
    .regPerm(regPerm), .regPid(regPid), .regPidMask(regPidMask),
    .verdictValid(verdictValid), .deny(deny), .noHit(noHit),
    .oneHit(oneHit), .multiHit(multiHit)
  );

  // Expected result nibble: {deny, noHit, oneHit, multiHit}
  localparam logic [3:0] G1 = 4'b0010, D1 = 4'b1010, GM = 4'b0001,
                         DM = 4'b1001, DN = 4'b1100;

  typedef struct packed {
    logic [31:0] addr;
    logic [2:0]  master;
    logic [1:0]  kind;
    logic        sup;
    logic [7:0]  pid;
    logic [3:0]  exp;
    logic [7:0]  req;   // requirement number for the message
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{32'h1004, 3'd0, 2'd0, 1'b0, 8'h00, G1, 8'd3},  // R3 user full
    '{32'h1004, 3'd1, 2'd1, 1'b0, 8'h00, D1, 8'd3},  // R3 user read-only, write refused
    '{32'h1004, 3'd1, 2'd0, 1'b0, 8'h00, G1, 8'd3},  // R3 user read-only, read ok
    '{32'h1004, 3'd1, 2'd1, 1'b1, 8'h00, G1, 8'd4},  // R4 code 0 rwx
    '{32'h1004, 3'd2, 2'd2, 1'b1, 8'h00, G1, 8'd4},  // R4 code 1 exec ok
    '{32'h1004, 3'd2, 2'd1, 1'b1, 8'h00, D1, 8'd4},  // R4 code 1 write refused
    '{32'h1004, 3'd3, 2'd0, 1'b1, 8'h00, G1, 8'd4},  // R4 code 2 read ok
    '{32'h1004, 3'd3, 2'd2, 1'b1, 8'h00, D1, 8'd4},  // R4 code 2 exec refused
    '{32'h1004, 3'd3, 2'd2, 1'b0, 8'h00, D1, 8'd3},  // R3 user write-only, exec refused
    '{32'h1004, 3'd3, 2'd1, 1'b0, 8'h00, G1, 8'd3},  // R3 user write ok
    '{32'h1004, 3'd0, 2'd1, 1'b1, 8'h00, G1, 8'd4},  // R4 code 3 follows user (7)
    '{32'h1004, 3'd4, 2'd0, 1'b0, 8'h00, G1, 8'd5},  // R5 m4 read enable
    '{32'h1004, 3'd4, 2'd1, 1'b1, 8'h00, D1, 8'd5},  // R5 m4 write refused
    '{32'h1004, 3'd4, 2'd2, 1'b0, 8'h00, G1, 8'd5},  // R5 exec as read
    '{32'h1004, 3'd5, 2'd0, 1'b0, 8'h00, D1, 8'd5},  // R5 m5 write-only
    '{32'h1004, 3'd5, 2'd1, 1'b0, 8'h00, G1, 8'd5},  // R5 m5 write ok
    '{32'h1004, 3'd5, 2'd2, 1'b0, 8'h00, D1, 8'd5},  // R5 m5 exec as read refused
    '{32'h1004, 3'd6, 2'd2, 1'b0, 8'h00, G1, 8'd5},  // R5 m6 both
    '{32'h1004, 3'd7, 2'd0, 1'b0, 8'h00, D1, 8'd5},  // R5 m7 none
    '{32'h1000, 3'd0, 2'd0, 1'b0, 8'h00, G1, 8'd1},  // R1 rounded start
    '{32'h0FFF, 3'd0, 2'd0, 1'b0, 8'h00, DN, 8'd1},  // R1 just below start
    '{32'h1FFF, 3'd0, 2'd0, 1'b0, 8'h00, GM, 8'd1},  // R1 rounded end, overlap
    '{32'h1800, 3'd1, 2'd1, 1'b1, 8'h00, GM, 8'd7},  // R7 one allows
    '{32'h1800, 3'd2, 2'd0, 1'b0, 8'h00, DM, 8'd7},  // R7 all refuse
    '{32'h2000, 3'd0, 2'd0, 1'b0, 8'h53, GM, 8'd6},  // R6 masked pid match
    '{32'h2000, 3'd0, 2'd0, 1'b0, 8'h6A, D1, 8'd6},  // R6 pid mismatch
    '{32'h2800, 3'd0, 2'd0, 1'b0, 8'h50, G1, 8'd6},  // R6 match alone
    '{32'h2800, 3'd0, 2'd0, 1'b0, 8'hA0, DN, 8'd6},  // R6 mismatch, no hit
    '{32'h2800, 3'd4, 2'd1, 1'b0, 8'hFF, D1, 8'd6},  // R6 plain master not qualified
    '{32'h2000, 3'd4, 2'd1, 1'b0, 8'h00, GM, 8'd7},  // R7 second region allows
    '{32'h4004, 3'd0, 2'd0, 1'b0, 8'h00, DN, 8'd2},  // R2 invalid region
    '{32'h8010, 3'd0, 2'd2, 1'b0, 8'h00, G1, 8'd3},  // R3 exec only
    '{32'h8010, 3'd0, 2'd0, 1'b0, 8'h00, D1, 8'd3},  // R3 read refused
    '{32'h8010, 3'd0, 2'd0, 1'b1, 8'h00, D1, 8'd4},  // R4 code 3 uses user
    '{32'h8010, 3'd0, 2'd3, 1'b0, 8'h00, G1, 8'd3},  // R3 kind 3 as exec
    '{32'h8020, 3'd0, 2'd2, 1'b0, 8'h00, DN, 8'd1}   // R1 past rounded end
  };

  function automatic logic [5:0] fld(input logic pe, input logic [1:0] sup, input logic [2:0] usr);
    return {pe, sup, usr};
  endfunction

  task automatic setRegion(input int r, input logic [31:0] s, input logic [31:0] e,
                           input logic v, input logic [31:0] p,
                           input logic [7:0] id, input logic [7:0] msk);
    regStart[r*32 +: 32] = s;
    regEnd[r*32 +: 32]   = e;
    regValid[r]          = v;
    regPerm[r*32 +: 32]  = p;
    regPid[r*8 +: 8]     = id;
    regPidMask[r*8 +: 8] = msk;
  endtask

  task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s got {vld,deny,no,one,multi}=%b expected %b", tag, got, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {verdictValid, deny, noHit, oneHit, multiHit};
  endfunction

  task automatic request(input logic [31:0] a, input logic [2:0] m, input logic [1:0] k,
                         input logic s, input logic [7:0] p);
    @(negedge clk);
    reqAddr = a; reqMaster = m; reqKind = k; reqSuper = s; reqPid = p;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    #100000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    regStart = '0; regEnd = '0; regPerm = '0; regValid = '0;
    regPid = '0; regPidMask = '0;
    // region 0: unaligned limits, mixed rights
    setRegion(0, 32'h101F, 32'h1FE0, 1'b1,
      {2'b00, 2'b11, 2'b10, 2'b01,
       fld(0, 2'd2, 3'd2), fld(0, 2'd1, 3'd0), fld(0, 2'd0, 3'd4), fld(0, 2'd3, 3'd7)},
      8'h00, 8'h00);
    // region 1: master 0 qualified by identifier 5A, low nibble ignored
    setRegion(1, 32'h2000, 32'h2FFF, 1'b1,
      {8'h00, fld(0, 2'd0, 3'd0), fld(0, 2'd0, 3'd0), fld(0, 2'd0, 3'd0), fld(1, 2'd3, 3'd7)},
      8'h5A, 8'h0F);
    // region 2: overlaps 0 and 1, refuses privileged masters, m4 full
    setRegion(2, 32'h1800, 32'h27FF, 1'b1,
      {6'b0, 2'b11, fld(0, 2'd3, 3'd0), fld(0, 2'd3, 3'd0), fld(0, 2'd3, 3'd0), fld(0, 2'd3, 3'd0)},
      8'h00, 8'h00);
    // region 3: wide open but invalid
    setRegion(3, 32'h4000, 32'h4FFF, 1'b0, 32'hFFFF_FFFF, 8'h00, 8'h00);
    // region 4: master 0 execute only
    setRegion(4, 32'h8000, 32'h801F, 1'b1,
      {8'h00, fld(0, 2'd0, 3'd0), fld(0, 2'd0, 3'd0), fld(0, 2'd0, 3'd0), fld(0, 2'd3, 3'd1)},
      8'h00, 8'h00);

    repeat (3) @(negedge clk);
    check("R11 outputs low in reset", outs(), 5'b00000);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 outputs low after reset", outs(), 5'b00000);

    for (int i = 0; i < NV; i++) begin
      request(VECS[i].addr, VECS[i].master, VECS[i].kind, VECS[i].sup, VECS[i].pid);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), outs(), {1'b1, VECS[i].exp});
    end

    // R10: verdict valid only in the cycle after the request, then quiet
    request(32'h0FFF, 3'd0, 2'd0, 1'b0, 8'h00);
    check("R10 verdict after request", outs(), 5'b11100);
    @(negedge clk);
    check("R10 quiet without request", outs(), 5'b00000);

    // R10: back-to-back requests each give their own verdict
    @(negedge clk);
    reqAddr = 32'h1004; reqMaster = 3'd0; reqKind = 2'd0; reqSuper = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    check("R10 back-to-back first", outs(), 5'b10010);
    reqAddr = 32'h8020;
    @(negedge clk);
    reqValid = 1'b0;
    check("R10 back-to-back second", outs(), 5'b11100);

    // R9: disabled checking grants an access that would have no hit
    globalEn = 1'b0;
    request(32'h0FFF, 3'd7, 2'd1, 1'b0, 8'h00);
    check("R9 bypass grants", outs(), 5'b10000);
    globalEn = 1'b1;

    // R2: clearing region 0 valid removes its hit
    regValid[0] = 1'b0;
    request(32'h1004, 3'd0, 2'd0, 1'b0, 8'h00);
    check("R2 region 0 invalidated", outs(), 5'b11100);
    regValid[0] = 1'b1;
    request(32'h1004, 3'd0, 2'd0, 1'b0, 8'h00);
    check("R2 region 0 restored", outs(), 5'b10010);

    finishRun();
  end

endmodule